// File: doc/BRIEF.md
# Fetch Return Unpacker

This block takes the data that comes back for one instruction fetch and turns it into individual instructions for the wavefront that asked for it. Each return names a wavefront slot, gives a byte length and carries a payload of 32-bit words. The block scans the payload from word 0 upward. Bit 31 of the first word of each instruction gives its length: 4 bytes (one word) or 8 bytes (two words). The block pushes the instructions one per cycle towards that slot's instruction buffer, and each one carries a running sequence number.

The block keeps two flags for each slot. A pending flag is set when a fetch is issued for the slot and cleared once its return has been dealt with. A drop flag is set when a redirect makes the slot's outstanding fetch stale. A return that arrives while the drop flag is set is thrown away whole. The buffer occupancy of every slot comes in from outside. The block uses it to flag returns that arrive while the buffer is too full, and drops that arrive while the buffer is not empty.

Top module: `fetch_return_unpacker`

## Requirements
- R1: A return holds floor(in_len / 4) words. A length above MAX_WORDS*4 bytes is clamped to MAX_WORDS words. Bytes beyond the last whole word are ignored.
- R2: When bit 31 of the word at the scan position is 1, the instruction is 8 bytes long. It is pushed with push_long=1 and push_inst = {next word, this word}, and scanning resumes two words later. Bit 31 of the second word is never read as a size bit.
- R3: When bit 31 of the word at the scan position is 0, the instruction is pushed with push_long=0 and push_inst = {32'h0, this word}.
- R4: At most one instruction is pushed per cycle, and push_slot gives the return's slot. A return is accepted when in_valid and in_ready are both high. From the cycle after that acceptance, in_ready stays low until the last word has been scanned. Instructions of the same return come out in consecutive cycles.
- R5: The sequence counter is cleared by reset and is SEQ_W bits wide. Every pushed instruction carries its current value, and the counter then advances by one, wrapping on overflow.
- R6: A pulse on flush_valid sets the drop flag of flush_slot. A return that is accepted while its slot's drop flag is set pushes nothing and clears that flag. The next return to that slot is unpacked normally.
- R7: When a dropped return is accepted and the slot's occupancy in ibuf_occ is not zero, err_drop_nonempty pulses for one cycle.
- R8: When a return that is not dropped is accepted and the slot's occupancy is above OCC_LIMIT (4), err_overfill pulses for one cycle. The return is still unpacked. An occupancy of exactly 4 raises no error.
- R9: A pulse on issue_valid sets fetch_pending for issue_slot. The flag is cleared once its return has been handled: at acceptance for a dropped or empty return, and together with the last push for an unpacked one.
- R10: An 8-byte instruction whose first word is the last word of the return is not pushed. err_truncated pulses instead.
- R11: A return with zero words pushes nothing, and in_ready stays high.
- R12: After reset, in_ready=1, push_valid=0, push_seq=0, every fetch_pending bit is 0 and every error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A fetch was issued for issue_slot |
| issue_slot | input | SLOT_W | Slot of the issued fetch |
| flush_valid | input | 1 | Mark the outstanding fetch of flush_slot as stale |
| flush_slot | input | SLOT_W | Slot being flushed |
| ibuf_occ | input | NUM_SLOTS*OCC_W | Buffer occupancy of each slot, slot k in bits [k*OCC_W +: OCC_W] |
| in_valid | input | 1 | Fetch return present |
| in_ready | output | 1 | Block can accept a return |
| in_slot | input | SLOT_W | Slot the return belongs to |
| in_len | input | LEN_W | Returned byte count |
| in_payload | input | MAX_WORDS*32 | Payload, word k in bits [32k +: 32] |
| push_valid | output | 1 | An instruction is presented this cycle |
| push_slot | output | SLOT_W | Target slot of the instruction |
| push_inst | output | 64 | Instruction bits |
| push_long | output | 1 | 1 = 8-byte instruction |
| push_seq | output | SEQ_W | Sequence number of the instruction |
| fetch_pending | output | NUM_SLOTS | Pending-fetch flag of each slot |
| err_overfill | output | 1 | Return arrived while the buffer held more than OCC_LIMIT entries |
| err_drop_nonempty | output | 1 | Dropped return arrived while the buffer was not empty |
| err_truncated | output | 1 | 8-byte instruction started in the last word |

## Verification
The scanner is fed payloads of only short words, of only long words, and of the two mixed. These show whether the scan step follows the size bit. One long instruction has a second word with bit 31 set, which shows whether a skipped word is wrongly decoded as a new instruction. The lengths used are not multiples of four, zero, and above the maximum, which separates the floor rule from the clamp. Drop, overfill and truncation patterns, together with occupancies of 4 and 5, separate discarding a return from unpacking it and test the occupancy limit at its edge.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef logic [31:0] word_t;

  function automatic logic word_is_long(input word_t w, input int size_bit);
    return w[size_bit];
  endfunction
endpackage

// File: rtl/fr_slot_flags.sv
module fr_slot_flags #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [SLOT_W-1:0]    issue_slot,
  input  logic                 flush_valid,
  input  logic [SLOT_W-1:0]    flush_slot,
  input  logic                 done_valid,
  input  logic [SLOT_W-1:0]    done_slot,
  input  logic                 done_dropped,
  output logic [NUM_SLOTS-1:0] pending,
  output logic [NUM_SLOTS-1:0] drop
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_issue, hit_flush, hit_done;
    assign hit_issue = issue_valid && (issue_slot == SLOT_W'(g));
    assign hit_flush = flush_valid && (flush_slot == SLOT_W'(g));
    assign hit_done  = done_valid  && (done_slot  == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        pending[g] <= 1'b0;
        drop[g]    <= 1'b0;
      end else begin
        if (hit_issue)     pending[g] <= 1'b1;
        else if (hit_done) pending[g] <= 1'b0;
        if (hit_flush)                     drop[g] <= 1'b1;
        else if (hit_done && done_dropped) drop[g] <= 1'b0;
      end
    end

    // R9: a pending flag only falls when a handled return names the slot
    assert_pending_clear_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(pending[g]) |-> $past(done_valid && done_slot == SLOT_W'(g)));
    // R6: a drop flag only rises after a flush of the slot
    assert_drop_set_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(drop[g]) |-> $past(flush_valid && flush_slot == SLOT_W'(g)));
  end
endmodule

// File: rtl/fr_word_scanner.sv
module fr_word_scanner
  import fr_pkg::*;
#(
  parameter int MAX_WORDS = 8,
  parameter int SIZE_BIT  = 31,
  parameter int CNT_W     = $clog2(MAX_WORDS + 2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [MAX_WORDS*32-1:0] load_payload,
  input  logic [CNT_W-1:0]        load_words,
  output logic                    busy,
  output logic                    emit_valid,
  output logic                    emit_long,
  output logic [63:0]             emit_inst,
  output logic                    emit_trunc,
  output logic                    scan_fin
);
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  word_t            words_q [MAX_WORDS];
  logic [CNT_W-1:0] nwords_q, idx_q, nxt_idx, adv;
  word_t            cur_w, nxt_w;
  logic             cur_long, has_next;

  assign nxt_idx  = idx_q + CNT_W'(1);
  assign cur_w    = words_q[idx_q[IDX_W-1:0]];
  assign nxt_w    = words_q[nxt_idx[IDX_W-1:0]];
  assign cur_long = word_is_long(cur_w, SIZE_BIT);
  assign has_next = nxt_idx < nwords_q;

  always_comb begin
    emit_valid = busy && !(cur_long && !has_next);
    emit_trunc = busy && cur_long && !has_next;
    emit_long  = cur_long && has_next;
    emit_inst  = emit_long ? {nxt_w, cur_w} : {32'h0, cur_w};
    adv        = emit_long ? (idx_q + CNT_W'(2)) : nxt_idx;
    scan_fin   = busy && (adv >= nwords_q);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < MAX_WORDS; k++) words_q[k] <= load_payload[k*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx_q    <= '0;
      nwords_q <= '0;
    end else if (load) begin
      busy     <= (load_words != '0);
      idx_q    <= '0;
      nwords_q <= load_words;
    end else if (busy) begin
      if (scan_fin) busy <= 1'b0;
      idx_q <= adv;
    end
  end

  // R2/R1: while scanning, the position always lies inside the return
  assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx_q < nwords_q));
  // R10: a truncated tail never produces an instruction in the same cycle
  assert_trunc_excl_R10: assert property (@(posedge clk) disable iff (rst)
    emit_trunc |-> !emit_valid);
endmodule

// File: rtl/fetch_return_unpacker.sv
module fetch_return_unpacker #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int MAX_WORDS = 8,
  parameter int LEN_W     = 8,
  parameter int OCC_W     = 4,
  parameter int OCC_LIMIT = 4,
  parameter int SEQ_W     = 32,
  parameter int SIZE_BIT  = 31
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       issue_valid,
  input  logic [SLOT_W-1:0]          issue_slot,
  input  logic                       flush_valid,
  input  logic [SLOT_W-1:0]          flush_slot,
  input  logic [NUM_SLOTS*OCC_W-1:0] ibuf_occ,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SLOT_W-1:0]          in_slot,
  input  logic [LEN_W-1:0]           in_len,
  input  logic [MAX_WORDS*32-1:0]    in_payload,
  output logic                       push_valid,
  output logic [SLOT_W-1:0]          push_slot,
  output logic [63:0]                push_inst,
  output logic                       push_long,
  output logic [SEQ_W-1:0]           push_seq,
  output logic [NUM_SLOTS-1:0]       fetch_pending,
  output logic                       err_overfill,
  output logic                       err_drop_nonempty,
  output logic                       err_truncated
);
  localparam int CNT_W = $clog2(MAX_WORDS + 2);

  logic                 accept, dropped, busy;
  logic [LEN_W-1:0]     len_words;
  logic [CNT_W-1:0]     nwords_in;
  logic [OCC_W-1:0]     occ_in;
  logic [NUM_SLOTS-1:0] drop_vec;
  logic [SLOT_W-1:0]    cur_slot_q, done_slot;
  logic                 done_valid;
  logic                 emit_valid, emit_long, emit_trunc, scan_fin;
  logic [63:0]          emit_inst;
  logic [SEQ_W-1:0]     seq_q;

  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign dropped   = drop_vec[in_slot];
  assign occ_in    = ibuf_occ[in_slot*OCC_W +: OCC_W];
  assign len_words = in_len >> 2;
  assign nwords_in = (len_words > LEN_W'(MAX_WORDS)) ? CNT_W'(MAX_WORDS)
                                                     : CNT_W'(len_words);

  assign done_valid = (accept && (dropped || nwords_in == '0)) || scan_fin;
  assign done_slot  = accept ? in_slot : cur_slot_q;

  fr_slot_flags #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_flags (
    .clk, .rst,
    .issue_valid, .issue_slot,
    .flush_valid, .flush_slot,
    .done_valid, .done_slot,
    .done_dropped (accept && dropped),
    .pending      (fetch_pending),
    .drop         (drop_vec)
  );

  fr_word_scanner #(.MAX_WORDS(MAX_WORDS), .SIZE_BIT(SIZE_BIT), .CNT_W(CNT_W)) u_scan (
    .clk, .rst,
    .load         (accept && !dropped),
    .load_payload (in_payload),
    .load_words   (nwords_in),
    .busy,
    .emit_valid, .emit_long, .emit_inst, .emit_trunc, .scan_fin
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_slot_q        <= '0;
      seq_q             <= '0;
      push_valid        <= 1'b0;
      push_slot         <= '0;
      push_inst         <= '0;
      push_long         <= 1'b0;
      push_seq          <= '0;
      err_overfill      <= 1'b0;
      err_drop_nonempty <= 1'b0;
      err_truncated     <= 1'b0;
    end else begin
      if (accept) cur_slot_q <= in_slot;
      push_valid <= emit_valid;
      if (emit_valid) begin
        push_slot <= cur_slot_q;
        push_inst <= emit_inst;
        push_long <= emit_long;
        push_seq  <= seq_q;
        seq_q     <= seq_q + SEQ_W'(1);
      end
      err_overfill      <= accept && !dropped && (occ_in > OCC_W'(OCC_LIMIT));
      err_drop_nonempty <= accept && dropped && (occ_in != '0);
      err_truncated     <= emit_trunc;
    end
  end

  // R5: the counter has moved exactly one past the number just presented
  assert_seq_step_R5: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> (seq_q == push_seq + SEQ_W'(1)));
  // R3: short instructions carry a zero upper half
  assert_short_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_long) |-> (push_inst[63:32] == 32'h0));
  // R4: pushes only follow cycles in which no new return could be accepted
  assert_busy_no_ready_R4: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> $past(!in_ready));
  // R10: a truncation report never coincides with a push
  assert_trunc_no_push_R10: assert property (@(posedge clk) disable iff (rst)
    err_truncated |-> !push_valid);
  // R6: a dropped return leaves the scanner idle
  assert_drop_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && dropped) |=> !busy);
endmodule

// File: tb/fetch_return_unpacker_tb.sv
`timescale 1ns/1ps
module fetch_return_unpacker_tb_top;
  localparam int NS = 4, SW = 2, MW = 8, LW = 8, OW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic issue_valid = 0, flush_valid = 0, in_valid = 0;
  logic [SW-1:0] issue_slot = '0, flush_slot = '0, in_slot = '0;
  logic [NS*OW-1:0] ibuf_occ = '0;
  logic [LW-1:0] in_len = '0;
  logic [MW*32-1:0] in_payload = '0;
  logic in_ready, push_valid, push_long;
  logic [SW-1:0] push_slot;
  logic [63:0] push_inst;
  logic [31:0] push_seq;
  logic [NS-1:0] fetch_pending;
  logic err_overfill, err_drop_nonempty, err_truncated;

  fetch_return_unpacker dut_i (
    .clk, .rst, .issue_valid, .issue_slot, .flush_valid, .flush_slot, .ibuf_occ,
    .in_valid, .in_ready, .in_slot, .in_len, .in_payload,
    .push_valid, .push_slot, .push_inst, .push_long, .push_seq,
    .fetch_pending, .err_overfill, .err_drop_nonempty, .err_truncated);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0, cap_n = 0;
  logic [63:0] cap_inst [32];
  logic        cap_long [32];
  logic [SW-1:0] cap_slot [32];
  logic [31:0] cap_seq [32];
  int          cap_cyc [32];
  bit st_over, st_drop, st_trunc;
  logic [31:0] exp_seq = 0;

  always @(negedge clk) begin
    cyc++;
    if (push_valid && cap_n < 32) begin
      cap_inst[cap_n] = push_inst; cap_long[cap_n] = push_long;
      cap_slot[cap_n] = push_slot; cap_seq[cap_n]  = push_seq;
      cap_cyc[cap_n]  = cyc;       cap_n++;
    end
    if (err_overfill) st_over = 1;
    if (err_drop_nonempty) st_drop = 1;
    if (err_truncated) st_trunc = 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [SW-1:0] V_SLOT [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd0};
  localparam logic [LW-1:0] V_LEN  [NV] = '{8'd16, 8'd24, 8'd32, 8'd10, 8'd12, 8'd16};
  localparam int V_CNT [NV] = '{4, 4, 8, 2, 2, 2};
  localparam bit V_TR  [NV] = '{0, 0, 0, 0, 1, 0};
  localparam logic [MW*32-1:0] V_PAY [NV] = '{
    {128'h0, 32'h00000044, 32'h00000033, 32'h00000022, 32'h00000011},
    {64'h0, 32'h00000006, 32'hBBBB0002, 32'h80000002, 32'h00000005, 32'hAAAA0001, 32'h80000001},
    {32'h08, 32'h07, 32'h06, 32'h05, 32'h04, 32'h03, 32'h02, 32'h01},
    {160'h0, 32'h00000079, 32'h00000078, 32'h00000077},
    {160'h0, 32'h80000003, 32'h00000002, 32'h00000001},
    {128'h0, 32'h87654321, 32'h8000FFFF, 32'h12345678, 32'h80000010}};

  task automatic pulse_issue(input int s);
    @(negedge clk); issue_valid = 1; issue_slot = SW'(s);
    @(negedge clk); issue_valid = 0;
  endtask

  task automatic pulse_flush(input int s);
    @(negedge clk); flush_valid = 1; flush_slot = SW'(s);
    @(negedge clk); flush_valid = 0;
  endtask

  // Issue, return, then compare every push with the unpacking rules.
  task automatic run_ret(input int s, input int len, input logic [MW*32-1:0] pay,
                         input int occ, input bit is_drop, input string req,
                         output int got, output bit mtrunc);
    int nw, i, ne;
    logic [63:0] e_inst [16];
    bit e_long [16];
    logic [31:0] w, w2;
    nw = len / 4; if (nw > MW) nw = MW;
    i = 0; ne = 0; mtrunc = 0;
    if (!is_drop) begin
      while (i < nw) begin
        w = pay[i*32 +: 32];
        if (w[31]) begin
          if (i + 1 < nw) begin
            w2 = pay[(i+1)*32 +: 32];
            e_inst[ne] = {w2, w}; e_long[ne] = 1; ne++; i += 2;
          end else begin mtrunc = 1; i += 1; end
        end else begin
          e_inst[ne] = {32'h0, w}; e_long[ne] = 0; ne++; i += 1;
        end
      end
    end
    pulse_issue(s);
    check(fetch_pending[s] == 1'b1, "R9 pending set", 64'(fetch_pending), 64'(1 << s));
    ibuf_occ[s*OW +: OW] = OW'(occ);
    cap_n = 0; st_over = 0; st_drop = 0; st_trunc = 0;
    @(negedge clk);
    check(in_ready == 1'b1, "R4 ready idle", 64'(in_ready), 64'd1);
    in_valid = 1; in_slot = SW'(s); in_len = LW'(len); in_payload = pay;
    @(negedge clk);
    in_valid = 0;
    if (!is_drop && nw > 0)
      check(in_ready == 1'b0, "R4 ready low while scanning", 64'(in_ready), 64'd0);
    else
      check(in_ready == 1'b1, "R11 ready stays high", 64'(in_ready), 64'd1);
    repeat (MW + 4) @(negedge clk);
    got = cap_n;
    check(cap_n == ne, {req, " push count"}, 64'(cap_n), 64'(ne));
    for (int k = 0; k < ne && k < cap_n; k++) begin
      check(cap_inst[k] == e_inst[k], {req, " inst R2 R3"}, cap_inst[k], e_inst[k]);
      check(cap_long[k] == e_long[k], {req, " size bit"}, 64'(cap_long[k]), 64'(e_long[k]));
      check(cap_slot[k] == SW'(s), {req, " slot R4"}, 64'(cap_slot[k]), 64'(s));
      check(cap_seq[k] == exp_seq, {req, " seq R5"}, 64'(cap_seq[k]), 64'(exp_seq));
      check(cap_cyc[k] == cap_cyc[0] + k, {req, " one per cycle R4"}, 64'(cap_cyc[k]), 64'(cap_cyc[0] + k));
      exp_seq++;
    end
    check(st_trunc == mtrunc, {req, " truncation R10"}, 64'(st_trunc), 64'(mtrunc));
    check(fetch_pending[s] == 1'b0, "R9 pending cleared", 64'(fetch_pending), 64'd0);
  endtask

  initial begin
    int got;
    bit mt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check(in_ready == 1, "R12 in_ready", 64'(in_ready), 64'd1);
    check(push_valid == 0, "R12 push_valid", 64'(push_valid), 64'd0);
    check(push_seq == 0, "R12 push_seq", 64'(push_seq), 64'd0);
    check(fetch_pending == 0, "R12 pending", 64'(fetch_pending), 64'd0);
    check({err_overfill, err_drop_nonempty, err_truncated} == 0, "R12 errors",
          64'({err_overfill, err_drop_nonempty, err_truncated}), 64'd0);

    // table of returns
    for (int v = 0; v < NV; v++) begin
      run_ret(V_SLOT[v], V_LEN[v], V_PAY[v], 0, 0, "R2 table", got, mt);
      check(got == V_CNT[v], "R1 table count", 64'(got), 64'(V_CNT[v]));
      check(mt == V_TR[v], "R10 table trunc", 64'(mt), 64'(V_TR[v]));
      check(st_over == 0, "R8 no overfill", 64'(st_over), 64'd0);
    end

    // R1 clamp above the maximum and floor below one word
    run_ret(0, 40, V_PAY[2], 0, 0, "R1 clamp", got, mt);
    check(got == 8, "R1 clamp count", 64'(got), 64'd8);
    run_ret(1, 3, V_PAY[0], 0, 0, "R11 three bytes", got, mt);
    run_ret(1, 0, V_PAY[0], 0, 0, "R11 zero length", got, mt);

    // R6 drop with empty buffer, then normal return to the same slot
    pulse_flush(2);
    run_ret(2, 16, V_PAY[0], 0, 1, "R6 dropped", got, mt);
    check(st_drop == 0, "R7 no error when empty", 64'(st_drop), 64'd0);
    run_ret(2, 16, V_PAY[0], 0, 0, "R6 after drop", got, mt);

    // R7 drop while the buffer holds entries
    pulse_flush(3);
    run_ret(3, 8, V_PAY[0], 2, 1, "R7 dropped", got, mt);
    check(st_drop == 1, "R7 drop nonempty flagged", 64'(st_drop), 64'd1);
    check(st_over == 0, "R7 no overfill on drop", 64'(st_over), 64'd0);

    // R8 occupancy limit
    run_ret(0, 8, V_PAY[0], 5, 0, "R8 overfill", got, mt);
    check(st_over == 1, "R8 overfill flagged", 64'(st_over), 64'd1);
    run_ret(0, 8, V_PAY[0], 4, 0, "R8 at limit", got, mt);
    check(st_over == 0, "R8 limit not flagged", 64'(st_over), 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule